// File: doc/BRIEF.md
# Preamble-Aligned Double Frame Buffer

This block turns a strobed byte stream from a host link into whole frames held in on-chip memory. It watches the stream for a run of identical sync bytes, throws away the single command byte that comes after that run, and writes the payload that follows into one of two frame memories. The payload has a fixed length.

Once the final payload byte is stored, the two memories trade roles. A consumer, such as a display refresh engine, reads through its own address/data port and always sees the memory that is not being written. Every frame has to be announced by a fresh sync run, and the payload address starts again at zero each time. A stray byte or a missing byte can therefore damage at most one frame. It never leaves a permanent shift in where data lands.

Top module: `pingpong_frame_buf`

## Requirements
- R1: No payload byte is stored until SYNC_LEN (default 3) consecutive accepted bytes have each equalled SYNC_BYTE. A shorter run followed by any other byte starts no frame.
- R2: During the sync search, an accepted byte that differs from SYNC_BYTE resets the count of matched bytes to zero.
- R3: The accepted byte that comes right after a complete sync run is a command byte. It is discarded and never written to a frame memory, whatever its value, including SYNC_BYTE.
- R4: The next FRAME_LEN accepted bytes are written in arrival order to addresses 0 through FRAME_LEN-1 of the memory being filled. No address is skipped or repeated, and byte values equal to SYNC_BYTE are stored like any other.
- R5: At the clock edge that accepts the last payload byte, `fill_sel` toggles, the write address returns to zero and the block resumes the sync search. `fill_sel` changes at no other time except reset.
- R6: `frame_done` is high for exactly one clock: the first cycle in which the new `fill_sel` value is visible.
- R7: `rd_data` shows the byte at `rd_addr` in the memory not being filled, sampled at a clock edge and valid one clock later.
- R8: A byte is accepted only on a rising clock edge with `in_valid` high. Cycles with `in_valid` low have no effect on sync, command or payload progress, whatever the value on `in_byte`.
- R9: Synchronous active-high reset clears the sync match count, abandons any partly received frame, sets the write address to zero, selects memory 0 for filling (`fill_sel` = 0) and holds `frame_done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe for `in_byte` |
| in_byte | input | DATA_W | Incoming stream byte |
| fill_sel | output | 1 | Index of the memory currently being filled |
| frame_done | output | 1 | One-clock pulse when the memories swap |
| rd_addr | input | ADDR_W | Consumer read address |
| rd_data | output | DATA_W | Consumer read data, one clock after the address |

## Verification
The bench builds the block with FRAME_LEN = 6, BUF_DEPTH = 10 and SYNC_LEN = 3. A frame then completes in about ten accepted bytes, so many swaps in both directions fit in a short run, and every frame can be read back in full and compared byte by byte. The shortened frames also let one run cover a sync run broken after two matches, a command byte equal to the sync value, payload bytes equal to the sync value, and idle gaps that carry the sync value. They also cover a reset in the middle of a frame followed by orphan payload bytes.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } sync_state_e;

endpackage

// File: rtl/pfb_framer.sv
module pfb_framer
  import pfb_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hA5,
  parameter int              SYNC_LEN  = 3,
  parameter int              FRAME_LEN = 2048,
  parameter int              ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_bank,
  output logic              fill_sel,
  output logic              frame_done
);

  localparam int                 CNT_W      = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam logic [CNT_W-1:0]  LAST_MATCH = CNT_W'(SYNC_LEN - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(FRAME_LEN - 1);

  sync_state_e       state_q;
  logic [CNT_W-1:0]  match_q;
  logic [ADDR_W-1:0] waddr_q;
  logic              sel_q;
  logic              done_q;

  // Memory write is taken straight from the accepted payload byte
  assign wr_en      = in_valid && (state_q == ST_DATA);
  assign wr_addr    = waddr_q;
  assign wr_data    = in_byte;
  assign wr_bank    = sel_q;
  assign fill_sel   = sel_q;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      match_q <= '0;
      waddr_q <= '0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_valid) begin
        case (state_q)
          ST_HUNT: begin
            if (in_byte == SYNC_BYTE) begin
              if (match_q == LAST_MATCH) begin
                match_q <= '0;
                state_q <= ST_CMD;
              end else begin
                match_q <= match_q + 1'b1;
              end
            end else begin
              match_q <= '0;
            end
          end
          ST_CMD: begin
            waddr_q <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (waddr_q == LAST_ADDR) begin
              waddr_q <= '0;
              sel_q   <= ~sel_q;
              done_q  <= 1'b1;
              state_q <= ST_HUNT;
            end else begin
              waddr_q <= waddr_q + 1'b1;
            end
          end
          default: begin
            match_q <= '0;
            state_q <= ST_HUNT;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pfb_ram.sv
module pfb_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3072,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: block RAM shape
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pfb_bank.sv
module pfb_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3072,
  parameter int ADDR_W = 12,
  parameter int NBUF   = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rq [NBUF];
  logic              rd_bank_q;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    pfb_ram #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W)
    ) u_ram (
      .clk  (clk),
      .we   (wr_en && (wr_bank == 1'(g))),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_addr),
      .rdata(rq[g])
    );
  end

  // Bank choice is registered alongside the RAM read
  always_ff @(posedge clk) begin
    rd_bank_q <= rd_bank;
  end

  assign rd_data = rq[rd_bank_q];

endmodule

// File: rtl/pingpong_frame_buf.sv
module pingpong_frame_buf #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hA5,
  parameter int                SYNC_LEN  = 3,
  parameter int                FRAME_LEN = 2048,
  parameter int                BUF_DEPTH = 3072,
  parameter int                ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              fill_sel,
  output logic              frame_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_bank;

  pfb_framer #(
    .DATA_W   (DATA_W),
    .SYNC_BYTE(SYNC_BYTE),
    .SYNC_LEN (SYNC_LEN),
    .FRAME_LEN(FRAME_LEN),
    .ADDR_W   (ADDR_W)
  ) u_framer (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_bank   (wr_bank),
    .fill_sel  (fill_sel),
    .frame_done(frame_done)
  );

  pfb_bank #(
    .DATA_W(DATA_W),
    .DEPTH (BUF_DEPTH),
    .ADDR_W(ADDR_W),
    .NBUF  (2)
  ) u_bank (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_bank(wr_bank),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_bank(~fill_sel),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int FRAME_LEN = 2048,
  parameter int ADDR_W    = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              fill_sel,
  input logic              frame_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R5
  swap_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (fill_sel != $past(fill_sel)));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> $stable(fill_sel));

  // R8
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> in_valid);

  // R4
  write_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < FRAME_LEN));

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!frame_done && !fill_sel));

endmodule

bind pingpong_frame_buf pfb_checker #(
  .FRAME_LEN(FRAME_LEN),
  .ADDR_W   (ADDR_W)
) u_pfb_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .fill_sel  (fill_sel),
  .frame_done(frame_done),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr)
);

// File: tb/pingpong_frame_buf_bench.sv
module pingpong_frame_buf_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          DW   = 8;
  localparam int          FL   = 6;
  localparam int          DEP  = 10;
  localparam int          SL   = 3;
  localparam int          AW   = $clog2(DEP);
  localparam logic [7:0]  SYNC = 8'h5A;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_byte = '0;
  logic          fill_sel;
  logic          frame_done;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int frames_seen = 0;
  bit mon_busy = 1'b0;
  bit exp_sel  = 1'b0;
  logic [DW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_frame_buf #(
    .DATA_W   (DW),
    .SYNC_BYTE(SYNC),
    .SYNC_LEN (SL),
    .FRAME_LEN(FL),
    .BUF_DEPTH(DEP)
  ) u_pingpong_frame_buf (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .fill_sel  (fill_sel),
    .frame_done(frame_done),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Gap cycles carry the sync value with in_valid low (R8)
  task automatic send_byte(input logic [DW-1:0] b, input int gap);
    repeat (gap) begin
      in_valid = 1'b0;
      in_byte  = SYNC;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_payload(input logic [DW-1:0] seed, input bit gaps, input int first);
    for (int i = first; i < FL; i++) begin
      logic [DW-1:0] b;
      b = (i == 2) ? SYNC : DW'(seed + 8'(i * 7));
      exp_q.push_back(b);
      send_byte(b, (gaps && (i % 2 == 1)) ? 2 : 0);
    end
  endtask

  task automatic wait_frame(input int target);
    wait (frames_seen == target);
    wait (!mon_busy);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    exp_sel = 1'b0;
    exp_q.delete();
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: on each swap, read the finished buffer and pop expectations
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && frame_done) begin
        mon_busy = 1'b1;
        exp_sel  = ~exp_sel;
        check(fill_sel == exp_sel, "R5 fill_sel after swap", int'(fill_sel), int'(exp_sel));
        for (int i = 0; i < FL; i++) begin
          logic [DW-1:0] e;
          rd_addr = AW'(i);
          @(negedge clk);
          if (i == 0) check(frame_done == 1'b0, "R6 pulse width", int'(frame_done), 0);
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
          check(rd_data === e, "R4/R7 payload readback", int'(rd_data), int'(e));
        end
        frames_seen++;
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int fs;
    do_reset();
    // R9: reset state
    check(fill_sel == 1'b0, "R9 fill_sel after reset", int'(fill_sel), 0);
    check(frame_done == 1'b0, "R9 frame_done after reset", int'(frame_done), 0);

    // R1 R3 R4: plain frame
    repeat (SL) send_byte(SYNC, 0);
    send_byte(8'h11, 0);
    send_payload(8'h20, 1'b0, 0);
    wait_frame(1);

    // R3 R8: command equal to sync, idle gaps carrying sync
    repeat (SL) send_byte(SYNC, 1);
    send_byte(SYNC, 3);
    send_payload(8'h40, 1'b1, 0);
    wait_frame(2);

    // R2: broken run restarts the count
    send_byte(8'h01, 0);
    send_byte(SYNC, 0);
    send_byte(SYNC, 0);
    send_byte(8'h00, 0);
    repeat (SL) send_byte(SYNC, 0);
    send_byte(8'h22, 0);
    send_payload(8'h61, 1'b0, 0);
    wait_frame(3);

    // R1 R5: short run then data, and stray bytes after a frame: no frame
    fs = frames_seen;
    send_byte(SYNC, 0);
    send_byte(SYNC, 0);
    for (int i = 0; i < FL + 4; i++) send_byte(8'h30 + 8'(i), 0);
    repeat (FL + 4) @(negedge clk);
    check(frames_seen == fs, "R1 no frame from short run", frames_seen, fs);
    check(fill_sel == exp_sel, "R1 fill_sel unchanged", int'(fill_sel), int'(exp_sel));

    // R9: reset in mid-frame abandons it
    repeat (SL) send_byte(SYNC, 0);
    send_byte(8'h44, 0);
    send_byte(8'h90, 0);
    send_byte(8'h91, 0);
    do_reset();
    check(fill_sel == 1'b0, "R9 fill_sel after mid-frame reset", int'(fill_sel), 0);
    check(frame_done == 1'b0, "R9 frame_done after mid-frame reset", int'(frame_done), 0);
    fs = frames_seen;
    for (int i = 2; i < FL; i++) send_byte(8'h92 + 8'(i), 0);
    repeat (FL + 4) @(negedge clk);
    check(frames_seen == fs, "R9 orphan payload ignored", frames_seen, fs);

    // R4 R7: a fresh frame after reset lands in memory 0, then memory 1
    repeat (SL) send_byte(SYNC, 0);
    send_byte(8'h55, 0);
    send_payload(8'hB0, 1'b1, 0);
    wait_frame(fs + 1);
    repeat (SL) send_byte(SYNC, 0);
    send_byte(8'h66, 0);
    send_payload(8'hC3, 1'b0, 0);
    wait_frame(fs + 2);
    check(exp_q.size() == 0, "R4 all payload consumed", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule